// File: doc/BRIEF.md
# Status Register Write Controller

This block holds a processor's current status word and a set of saved status words, one for each privileged exception bank. It applies the field-masked writes that a move-to-status instruction issues. Each write carries a 4-bit field mask and a 32-bit data word, and targets either the current word or the saved word of the active bank. The active bank is taken from the mode field of the current word. The block merges the selected fields into the target and limits a user-mode write to the condition flags. It also trims the current word when the core runs in its 26-bit compatible configuration.

The block unpacks the flag and interrupt-disable bits from the current word for the rest of the core. When a write to the current word changes its mode field, the block tells the register file with a one-cycle request. It also drives a privilege line for memory transfers. Instruction decode and the ALU sit outside this block.

Top module: `sr_write_ctrl`

## Requirements
- R1: Reset loads the current word with 0x000000D3 when `prog32` is high and with 0x000000C3 when it is low. All saved words reset to zero.
- R2: In a privileged bank, a current-word write whose mask is exactly 4'b1001 replaces the whole word. Mask bit 0 is the control field and mask bit 3 is the flags field.
- R3: In a privileged bank, a current-word write with mask bit 0 set and a mask other than 4'b1001 changes only bits 7, 6 and 4..0. Mask bit 3 has no effect in that case.
- R4: In a privileged bank, a current-word write with mask bit 0 clear and mask bit 3 set changes only bits 31..28. When both mask bits are clear, nothing changes.
- R5: In the user bank (mode 0x10 or 0x00), a current-word write changes only bits 31..28, and only when mask bit 3 is set. All other bits keep their value.
- R6: While `prog32` is low, every current-word write also clears all bits except 31..28, 7, 6, 1 and 0.
- R7: A saved-word write in the fiq (0x11/0x01), irq (0x12/0x02), svc (0x13/0x03), abort (0x17) or undefined (0x1B) bank uses the same mask precedence as R2 to R4, without the user limit. It changes only that bank's saved word and never the current word.
- R8: In the user and system (0x1F) banks, and for any unlisted mode value, `spsr_rd` shows the current word and saved-word writes are ignored.
- R9: `mode_chg` pulses for exactly one cycle, in the cycle after a current-word write, when the write changed bits 4..0. `mode_new` then holds the new mode. Otherwise `mode_chg` stays low.
- R10: `flag_n`, `flag_z`, `flag_c` and `flag_v` follow bits 31, 30, 29 and 28 of the current word without delay. `irq_dis` and `fiq_dis` follow bits 7 and 6.
- R11: `priv_xfer` is high exactly when bits 1..0 of the current mode are not both zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Write strobe for one cycle |
| wr_saved | input | 1 | 1 selects the saved word of the active bank, 0 the current word |
| fmask | input | 4 | Field mask; bit 0 control, bit 3 flags |
| wdata | input | 32 | Write data |
| prog32 | input | 1 | 32-bit configuration; low trims to the 26-bit compatible fields |
| cpsr | output | 32 | Current status word |
| spsr_rd | output | 32 | Saved word of the active bank, or the current word where there is none |
| flag_n | output | 1 | Negative flag |
| flag_z | output | 1 | Zero flag |
| flag_c | output | 1 | Carry flag |
| flag_v | output | 1 | Overflow flag |
| irq_dis | output | 1 | IRQ disable |
| fiq_dis | output | 1 | FIQ disable |
| mode_chg | output | 1 | Bank-switch request pulse |
| mode_new | output | 5 | Mode for the requested switch |
| priv_xfer | output | 1 | Privileged-transfer indication |

## Verification
Every cycle, the assertions check four things. A user-mode write touches no bit below the flags. Saved-word writes never disturb the current word, and they leave the read-back unchanged where the bank has no saved word. A trimmed write leaves no stray bits. A mode-change pulse only follows a real change of mode and always comes with the matching mode value. The exact merge result for each of the sixteen masks, the reset values, the separate storage of each bank's saved word and the unpacked flag outputs can only be shown by the bench's sweeps over masks, modes, data patterns and both configurations.

// File: rtl/sr_ctl_pkg.sv
package sr_ctl_pkg;

   typedef enum logic [2:0] {
      BK_USR  = 3'd0,
      BK_FIQ  = 3'd1,
      BK_IRQ  = 3'd2,
      BK_SVC  = 3'd3,
      BK_ABT  = 3'd4,
      BK_UND  = 3'd5,
      BK_SYS  = 3'd6,
      BK_NONE = 3'd7
   } bank_e;

   // Number of banks that own a saved word (fiq .. und).
   localparam int unsigned SAVED_BANKS = 5;

   function automatic bank_e mode_bank(input logic [4:0] m);
      bank_e b;
      case (m)
         5'h00, 5'h10: b = BK_USR;
         5'h01, 5'h11: b = BK_FIQ;
         5'h02, 5'h12: b = BK_IRQ;
         5'h03, 5'h13: b = BK_SVC;
         5'h17:        b = BK_ABT;
         5'h1B:        b = BK_UND;
         5'h1F:        b = BK_SYS;
         default:      b = BK_NONE;
      endcase
      return b;
   endfunction

endpackage

// File: rtl/sr_bank_decode.sv
module sr_bank_decode
   import sr_ctl_pkg::*;
#(
   parameter int unsigned MODE_W = 5
) (
   input  logic [MODE_W-1:0] mode,
   output bank_e             bank,
   output logic              user_only,
   output logic              saved_ok
);
   generate
      if (MODE_W != 5) begin : g_bad_mode
         $error("sr_bank_decode: MODE_W must be 5");
      end
   endgenerate

   always_comb begin
      bank      = mode_bank(mode[4:0]);
      user_only = (bank == BK_USR);
      saved_ok  = (bank != BK_USR) && (bank != BK_SYS) && (bank != BK_NONE);
   end
endmodule

// File: rtl/sr_field_merge.sv
module sr_field_merge #(
   parameter int unsigned DW       = 32,
   parameter int unsigned FLAG_LSB = 28,
   parameter int unsigned IRQ_BIT  = 7,
   parameter int unsigned FIQ_BIT  = 6,
   parameter int unsigned MODE_W   = 5
) (
   input  logic [DW-1:0] old_val,
   input  logic [DW-1:0] wdata,
   input  logic [3:0]    fmask,
   input  logic          user_only,
   output logic [DW-1:0] merged
);
   localparam logic [DW-1:0] FLAG_M = {{(DW-FLAG_LSB){1'b1}}, {FLAG_LSB{1'b0}}};
   localparam logic [DW-1:0] MODE_M = {{(DW-MODE_W){1'b0}}, {MODE_W{1'b1}}};
   localparam logic [DW-1:0] CTL_M  = MODE_M | (DW'(1) << IRQ_BIT) | (DW'(1) << FIQ_BIT);
   localparam logic [3:0]    FULL_MASK = 4'b1001;

   generate
      if (FLAG_LSB + 4 != DW) begin : g_bad_flags
         $error("sr_field_merge: flags must fill the top nibble");
      end
      if (IRQ_BIT < MODE_W || FIQ_BIT < MODE_W || IRQ_BIT >= FLAG_LSB) begin : g_bad_ctl
         $error("sr_field_merge: interrupt bits overlap another field");
      end
   endgenerate

   logic [DW-1:0] sel_m;

   always_comb begin
      sel_m = '0;
      if (user_only) begin
         if (fmask[3]) sel_m = FLAG_M;
      end else if (fmask == FULL_MASK) begin
         sel_m = '1;
      end else if (fmask[0]) begin
         sel_m = CTL_M;
      end else if (fmask[3]) begin
         sel_m = FLAG_M;
      end
      merged = (old_val & ~sel_m) | (wdata & sel_m);
   end
endmodule

// File: rtl/sr_saved_file.sv
module sr_saved_file
   import sr_ctl_pkg::*;
#(
   parameter int unsigned DW     = 32,
   parameter int unsigned N_BANK = SAVED_BANKS
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          we,
   input  bank_e         bank,
   input  logic [DW-1:0] wdata,
   output logic [DW-1:0] rd
);
   generate
      if (N_BANK != SAVED_BANKS) begin : g_bad_n
         $error("sr_saved_file: N_BANK must match the bank encoding");
      end
   endgenerate

   logic [DW-1:0] store [N_BANK];

   generate
      for (genvar i = 0; i < N_BANK; i++) begin : g_bank
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               store[i] <= '0;
            else if (we && (bank == bank_e'(i + 1)))
               store[i] <= wdata;
         end
      end
   endgenerate

   always_comb begin
      rd = '0;
      for (int i = 0; i < N_BANK; i++)
         if (bank == bank_e'(i + 1)) rd = store[i];
   end
endmodule

// File: rtl/sr_write_ctrl.sv
module sr_write_ctrl
   import sr_ctl_pkg::*;
#(
   parameter int unsigned    DW       = 32,
   parameter int unsigned    FLAG_LSB = 28,
   parameter int unsigned    IRQ_BIT  = 7,
   parameter int unsigned    FIQ_BIT  = 6,
   parameter int unsigned    MODE_W   = 5,
   parameter int unsigned    LEG_MW   = 2,
   parameter logic [MODE_W-1:0] RST_MODE = 5'h13
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic              wr_saved,
   input  logic [3:0]        fmask,
   input  logic [31:0]       wdata,
   input  logic              prog32,
   output logic [31:0]       cpsr,
   output logic [31:0]       spsr_rd,
   output logic              flag_n,
   output logic              flag_z,
   output logic              flag_c,
   output logic              flag_v,
   output logic              irq_dis,
   output logic              fiq_dis,
   output logic              mode_chg,
   output logic [4:0]        mode_new,
   output logic              priv_xfer
);
   localparam logic [DW-1:0] FLAG_M  = {{(DW-FLAG_LSB){1'b1}}, {FLAG_LSB{1'b0}}};
   localparam logic [DW-1:0] INT_M   = (DW'(1) << IRQ_BIT) | (DW'(1) << FIQ_BIT);
   localparam logic [DW-1:0] LEG_M   = FLAG_M | INT_M | DW'((1 << LEG_MW) - 1);
   localparam logic [DW-1:0] RST_VAL = INT_M | DW'(RST_MODE);

   generate
      if (DW != 32) begin : g_bad_dw
         $error("sr_write_ctrl: port widths assume DW == 32");
      end
      if (LEG_MW >= MODE_W) begin : g_bad_leg
         $error("sr_write_ctrl: legacy mode field must be narrower than the mode");
      end
   endgenerate

   logic [DW-1:0]     cur_q, cur_d, saved_raw;
   logic [DW-1:0]     mrg [2];
   logic [DW-1:0]     mrg_old [2];
   logic              mrg_usr [2];
   bank_e             bank;
   logic              user_only, saved_ok;
   logic              cur_wr, sav_wr;

   sr_bank_decode #(.MODE_W(MODE_W)) u_dec (
      .mode      (cur_q[MODE_W-1:0]),
      .bank      (bank),
      .user_only (user_only),
      .saved_ok  (saved_ok)
   );

   assign mrg_old[0] = cur_q;
   assign mrg_old[1] = saved_raw;
   assign mrg_usr[0] = user_only;
   assign mrg_usr[1] = 1'b0;

   // index 0 merges into the current word, index 1 into the saved word
   generate
      for (genvar t = 0; t < 2; t++) begin : g_merge
         sr_field_merge #(
            .DW(DW), .FLAG_LSB(FLAG_LSB), .IRQ_BIT(IRQ_BIT),
            .FIQ_BIT(FIQ_BIT), .MODE_W(MODE_W)
         ) u_mrg (
            .old_val   (mrg_old[t]),
            .wdata     (wdata),
            .fmask     (fmask),
            .user_only (mrg_usr[t]),
            .merged    (mrg[t])
         );
      end
   endgenerate

   assign cur_wr = wr_en && !wr_saved;
   assign sav_wr = wr_en && wr_saved && saved_ok;

   sr_saved_file #(.DW(DW), .N_BANK(SAVED_BANKS)) u_saved (
      .clk   (clk),
      .rst_n (rst_n),
      .we    (sav_wr),
      .bank  (bank),
      .wdata (mrg[1]),
      .rd    (saved_raw)
   );

   always_comb begin
      cur_d = cur_q;
      if (cur_wr) cur_d = prog32 ? mrg[0] : (mrg[0] & LEG_M);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cur_q    <= prog32 ? RST_VAL : (RST_VAL & LEG_M);
         mode_chg <= 1'b0;
         mode_new <= '0;
      end else begin
         cur_q    <= cur_d;
         mode_chg <= cur_wr && (cur_d[MODE_W-1:0] != cur_q[MODE_W-1:0]);
         mode_new <= cur_d[4:0];
      end
   end

   assign cpsr      = cur_q;
   assign spsr_rd   = saved_ok ? saved_raw : cur_q;
   assign flag_n    = cur_q[FLAG_LSB+3];
   assign flag_z    = cur_q[FLAG_LSB+2];
   assign flag_c    = cur_q[FLAG_LSB+1];
   assign flag_v    = cur_q[FLAG_LSB];
   assign irq_dis   = cur_q[IRQ_BIT];
   assign fiq_dis   = cur_q[FIQ_BIT];
   assign priv_xfer = |cur_q[1:0];
endmodule

// File: rtl/sr_write_ctrl_chk.sv
module sr_write_ctrl_chk (
   input logic        clk,
   input logic        rst_n,
   input logic        wr_en,
   input logic        wr_saved,
   input logic        prog32,
   input logic [31:0] cpsr,
   input logic [31:0] spsr_rd,
   input logic        mode_chg,
   input logic [4:0]  mode_new
);
   logic usr_mode, has_saved;
   assign usr_mode  = (cpsr[4:0] == 5'h10) || (cpsr[4:0] == 5'h00);
   assign has_saved = (cpsr[4:0] inside {5'h01, 5'h02, 5'h03, 5'h11, 5'h12,
                                         5'h13, 5'h17, 5'h1B});

   // R5
   user_flags_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && !wr_saved && usr_mode) |=> (cpsr[27:0] == $past(cpsr[27:0])));

   // R7
   saved_keeps_cur_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_saved) |=> $stable(cpsr));

   // R8
   saved_blocked_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_saved && !has_saved) |=> $stable(spsr_rd));

   // R6
   legacy_trim_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && !wr_saved && !prog32) |=> ((cpsr & ~32'hF000_00C3) == 32'h0));

   // R9
   mode_pulse_real_chk: assert property (@(posedge clk) disable iff (!rst_n)
      mode_chg |-> ((cpsr[4:0] != $past(cpsr[4:0])) && (mode_new == cpsr[4:0])));

   // R9
   no_idle_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_en |=> !mode_chg);
endmodule

bind sr_write_ctrl sr_write_ctrl_chk u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .wr_en    (wr_en),
   .wr_saved (wr_saved),
   .prog32   (prog32),
   .cpsr     (cpsr),
   .spsr_rd  (spsr_rd),
   .mode_chg (mode_chg),
   .mode_new (mode_new)
);

// File: tb/sr_write_ctrl_bench.sv
`timescale 1ns/1ps
module sr_write_ctrl_bench;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr_en = 1'b0, wr_saved = 1'b0, prog32 = 1'b1;
   logic [3:0]  fmask = '0;
   logic [31:0] wdata = '0;
   logic [31:0] cpsr, spsr_rd;
   logic        flag_n, flag_z, flag_c, flag_v, irq_dis, fiq_dis;
   logic        mode_chg, priv_xfer;
   logic [4:0]  mode_new;

   int n_chk = 0, n_bad = 0;

   always #2 clk = ~clk;

   sr_write_ctrl u_sr_write_ctrl (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_saved(wr_saved),
      .fmask(fmask), .wdata(wdata), .prog32(prog32), .cpsr(cpsr),
      .spsr_rd(spsr_rd), .flag_n(flag_n), .flag_z(flag_z), .flag_c(flag_c),
      .flag_v(flag_v), .irq_dis(irq_dis), .fiq_dis(fiq_dis),
      .mode_chg(mode_chg), .mode_new(mode_new), .priv_xfer(priv_xfer)
   );

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   // expected merge per R2..R6 (cur=1) or R7 (cur=0)
   function automatic logic [31:0] model(input logic [31:0] old, input logic [31:0] d,
                                         input logic [3:0] k, input bit usr,
                                         input bit p, input bit cur);
      logic [31:0] fl, ct, r;
      fl = 32'hF000_0000;
      ct = 32'h0000_00DF;
      r  = old;
      if (usr) begin
         if (k[3]) r = (old & ~fl) | (d & fl);
      end else if (k == 4'b1001) r = d;
      else if (k[0]) r = (old & ~ct) | (d & ct);
      else if (k[3]) r = (old & ~fl) | (d & fl);
      if (cur && !p) r = r & 32'hF000_00C3;
      return r;
   endfunction

   task automatic do_reset(input bit p);
      @(negedge clk);
      prog32 = p;
      rst_n  = 1'b0;
      wr_en  = 1'b0;
      @(negedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
   endtask

   // drive one write; on return outputs show its result
   task automatic do_write(input bit sv, input logic [3:0] k, input logic [31:0] d);
      wr_en    = 1'b1;
      wr_saved = sv;
      fmask    = k;
      wdata    = d;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   logic [31:0] pats [3];
   logic [4:0]  modes [4];

   initial begin
      pats[0]  = 32'hA5A5_5A5A;
      pats[1]  = 32'h3C00_0051;
      pats[2]  = 32'hF0FF_FF9F;
      modes[0] = 5'h10;
      modes[1] = 5'h13;
      modes[2] = 5'h1F;
      modes[3] = 5'h11;

      // R1 reset values for both configurations
      do_reset(1'b1);
      check("R1 reset p32", cpsr, 32'h0000_00D3);
      check("R7 saved reset", spsr_rd, 32'h0);
      check("R9 no pulse at reset", {31'b0, mode_chg}, 32'h0);
      do_reset(1'b0);
      check("R1 reset p26", cpsr, 32'h0000_00C3);

      // current-word sweep: R2 R3 R4 R5 R6 R9 R10 R11
      for (int p = 1; p >= 0; p--) begin
         for (int mi = 0; mi < 4; mi++) begin
            for (int k = 0; k < 16; k++) begin
               for (int di = 0; di < 3; di++) begin
                  logic [31:0] base, exp;
                  logic [4:0]  em;
                  bit          usr;
                  do_reset(p[0]);
                  do_write(1'b0, 4'b1001, 32'h5000_00C0 | 32'(modes[mi]));
                  base = (32'h5000_00C0 | 32'(modes[mi])) & (p[0] ? 32'hFFFF_FFFF : 32'hF000_00C3);
                  check("R2 setup", cpsr, base);
                  em  = base[4:0];
                  usr = (em == 5'h10) || (em == 5'h00);
                  do_write(1'b0, k[3:0], pats[di]);
                  exp = model(base, pats[di], k[3:0], usr, p[0], 1'b1);
                  check(usr ? "R5 user write" : (k == 9 ? "R2 full" : (k[0] ? "R3 ctl" : "R4 flags")),
                        cpsr, exp);
                  if (!p[0]) check("R6 trim", cpsr & ~32'hF000_00C3, 32'h0);
                  check("R9 pulse", {31'b0, mode_chg}, {31'b0, exp[4:0] != em});
                  if (exp[4:0] != em) check("R9 mode_new", {27'b0, mode_new}, {27'b0, exp[4:0]});
                  check("R10 unpack", {26'b0, flag_n, flag_z, flag_c, flag_v, irq_dis, fiq_dis},
                        {26'b0, exp[31:28], exp[7], exp[6]});
                  check("R11 priv", {31'b0, priv_xfer}, {31'b0, exp[1:0] != 2'b00});
                  @(negedge clk);
                  check("R9 one cycle", {31'b0, mode_chg}, 32'h0);
               end
            end
         end
      end

      // saved-word sweep: R7 in svc, R8 in system
      for (int k = 0; k < 16; k++) begin
         for (int di = 0; di < 3; di++) begin
            do_reset(1'b1);
            do_write(1'b1, k[3:0], pats[di]);
            check("R7 saved merge", spsr_rd, model(32'h0, pats[di], k[3:0], 1'b0, 1'b1, 1'b0));
            check("R7 cur kept", cpsr, 32'h0000_00D3);
            do_write(1'b0, 4'b1001, 32'h0000_00DF);
            do_write(1'b1, k[3:0], pats[di]);
            check("R8 sys read", spsr_rd, 32'h0000_00DF);
            do_write(1'b0, 4'b1001, 32'h0000_00D3);
            check("R8 sys write ignored", spsr_rd,
                  model(32'h0, pats[di], k[3:0], 1'b0, 1'b1, 1'b0));
         end
      end

      // R7 per-bank storage, R8 undefined mode value
      do_reset(1'b1);
      do_write(1'b0, 4'b1001, 32'h0000_00D1);
      do_write(1'b1, 4'b1001, 32'h1234_5678);
      check("R7 fiq saved", spsr_rd, 32'h1234_5678);
      do_write(1'b0, 4'b1001, 32'h0000_00D3);
      check("R7 svc separate", spsr_rd, 32'h0);
      do_write(1'b0, 4'b1001, 32'h0000_00D1);
      check("R7 fiq kept", spsr_rd, 32'h1234_5678);
      do_write(1'b0, 4'b1001, 32'h0000_00DA);
      do_write(1'b1, 4'b1001, 32'hFFFF_FFFF);
      check("R8 odd mode read", spsr_rd, 32'h0000_00DA);

      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end

   initial begin
      #(200000 * 4);
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end
endmodule